// File: doc/BRIEF.md
# Clock Timer Interrupt Flag Unit

This block turns a slow clock-timer divider into three periodic interrupt sources at 32 Hz, 8 Hz and 2 Hz. A single-cycle enable pulse at 256 Hz advances a binary divider. A detector watches three of the divider's outputs and records each high-to-low transition in a sticky event flag.

The flags record events whatever the enable mask holds. A processor reaches the unit through a small 4-bit register port. One address returns the flags and clears them as a side effect of the read, so software must take a single snapshot into a buffer. The other address holds the per-source enable mask. The interrupt request is high while any recorded flag is also enabled.

Top module: `tmr_irq_unit`

## Requirements
- R1: After reset, the 32 Hz flag (flag bit 0) is set once for every 8 tick pulses. The 8 Hz flag (bit 1) is set once for every 32 ticks, and the 2 Hz flag (bit 2) once for every 128 ticks. The first event of each comes at the 8th, 32nd and 128th tick.
- R2: A flag set by a tick sampled at clock edge E is visible at the outputs after edge E+1.
- R3: A flag is set on its event even when its mask bit is 0. A masked flag does not raise irq_o.
- R4: A read with addr_i=0 returns the flags on rdata_o[2:0], combinationally, while rd_i is high. The flags are cleared at the clock edge that samples the read.
- R5: If a flag's event lands on the same edge as a flag read, that flag stays set after the read.
- R6: A write with addr_i=1 loads wdata_i[2:0] into the mask. A read with addr_i=1 returns the mask on rdata_o[2:0].
- R7: irq_o is 1 exactly when some bit is set in both the flags and the mask. It goes low after the enabled flags are cleared or masked.
- R8: A write with addr_i=0 leaves the flags unchanged.
- R9: With rst_n low, the flags, the mask and the divider are cleared. Bit 3 of rdata_o always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle 256 Hz enable pulse |
| addr_i | input | 1 | Register select: 0 selects the flags, 1 selects the mask |
| rd_i | input | 1 | Read strobe; a flag read clears the flags |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 4 | Write data |
| rdata_o | output | 4 | Read data, combinational from the selected register |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Read data and irq_o follow the register state with no added delay. A mask write or a read-clear is therefore visible just after the next clock edge. A tick needs two edges before its flag shows: one to step the divider and one to latch the edge.

The bench drives its inputs on falling clock edges and samples shortly after them. After each tick burst it waits two further cycles before it checks anything. The latency check samples irq_o one cycle after the tick, where it must still be low, and again one cycle later, where it must be high. The same-edge read test raises the read strobe in the cycle in which the edge pulse is live.

// File: rtl/tmr_irq_pkg.sv
// Shared constants for the clock timer interrupt unit.
// Assumes taps sit at every second divider bit, starting at bit 2.
package tmr_irq_pkg;
    localparam int N_SRC = 3;   // number of timer interrupt sources
    localparam int REG_W = 4;   // bus data width
    localparam int DIV_W = 7;   // divider width (256 Hz / 128 = 2 Hz)
    localparam logic ADDR_FLAG = 1'b0;
    localparam logic ADDR_MASK = 1'b1;

    // Divider bit whose falling edge marks source i (divide by 8, 32, 128)
    function automatic int tap_pos(input int i);
        return 2 + 2 * i;
    endfunction
endpackage

// File: rtl/tmr_div.sv
// Binary divider stepped by a 256 Hz enable pulse; exposes the source taps.
// Assumes tick_i is high for one clock per 256 Hz period.
module tmr_div
    import tmr_irq_pkg::*;
#(
    parameter int DW = DIV_W,
    parameter int NS = N_SRC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    output logic [NS-1:0] tap_o
);
    logic [DW-1:0] cnt_q;

    // Count tick pulses; reset clears the chain
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (tick_i) cnt_q <= cnt_q + 1'b1;
    end

    for (genvar g = 0; g < NS; g++) begin : g_tap
        assign tap_o[g] = cnt_q[tap_pos(g)];
    end
endmodule

// File: rtl/tmr_fall_det.sv
// Produces a one-cycle pulse on each high-to-low transition of every tap.
// Assumes taps come from registers in the same clock domain.
module tmr_fall_det #(
    parameter int NS = tmr_irq_pkg::N_SRC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] tap_i,
    output logic [NS-1:0] fall_o
);
    logic [NS-1:0] prev_q;

    // Remember last tap levels; divider resets to zero, so do these
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= tap_i;
    end

    assign fall_o = prev_q & ~tap_i;
endmodule

// File: rtl/tmr_flag_bank.sv
// Holds the sticky event flags and the enable mask; serves the register port.
// Assumes rd_i and wr_i are single-cycle strobes; a flag read clears on its edge.
module tmr_flag_bank
    import tmr_irq_pkg::*;
#(
    parameter int NS = N_SRC,
    parameter int RW = REG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] fall_i,
    input  logic          addr_i,
    input  logic          rd_i,
    input  logic          wr_i,
    input  logic [RW-1:0] wdata_i,
    output logic [RW-1:0] rdata_o,
    output logic [NS-1:0] flag_o,
    output logic [NS-1:0] mask_o
);
    logic [NS-1:0] flag_q;
    logic [NS-1:0] mask_q;
    logic          rd_flag;
    logic          wr_mask;
    logic          unused_hi;

    assign rd_flag   = rd_i && (addr_i == ADDR_FLAG);
    assign wr_mask   = wr_i && (addr_i == ADDR_MASK);
    assign unused_hi = &{1'b0, wdata_i[RW-1:NS]};

    // Flags: clear on read, but a same-edge event wins
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~{NS{rd_flag}}) | fall_i;
    end

    // Mask: loaded by writes to its address
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mask) mask_q <= wdata_i[NS-1:0];
    end

    // Read mux; upper bits return zero
    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_FLAG) rdata_o[NS-1:0] = flag_q;
        else                     rdata_o[NS-1:0] = mask_q;
    end

    assign flag_o = flag_q;
    assign mask_o = mask_q;
endmodule

// File: rtl/tmr_irq_unit.sv
// Top of the clock timer interrupt unit: divider, edge detect, flags, request.
// Assumes a single clock; tick_i is a 256 Hz enable in that domain.
module tmr_irq_unit
    import tmr_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             addr_i,
    input  logic             rd_i,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] rdata_o,
    output logic             irq_o
);
    logic [N_SRC-1:0] tap_w;
    logic [N_SRC-1:0] fall_w;
    logic [N_SRC-1:0] flag_w;
    logic [N_SRC-1:0] mask_w;

    tmr_div #(.DW(DIV_W), .NS(N_SRC)) u_div (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .tap_o(tap_w)
    );

    tmr_fall_det #(.NS(N_SRC)) u_fall (
        .clk(clk), .rst_n(rst_n), .tap_i(tap_w), .fall_o(fall_w)
    );

    tmr_flag_bank #(.NS(N_SRC), .RW(REG_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .fall_i(fall_w), .addr_i(addr_i),
        .rd_i(rd_i), .wr_i(wr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .flag_o(flag_w), .mask_o(mask_w)
    );

    // Request while any enabled source has a pending event
    assign irq_o = |(flag_w & mask_w);
endmodule

// File: rtl/tmr_irq_unit_chk.sv
// Property checker for tmr_irq_unit, attached with bind.
module tmr_irq_unit_chk
    import tmr_irq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             addr_i,
    input logic             rd_i,
    input logic             wr_i,
    input logic [REG_W-1:0] wdata_i,
    input logic [REG_W-1:0] rdata_o,
    input logic             irq_o,
    input logic [N_SRC-1:0] flag_q,
    input logic [N_SRC-1:0] fall,
    input logic [N_SRC-1:0] mask
);
    // R3: an edge pulse always sets its flag, mask or not
    p_edge_sets_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fall != '0) |=> ((flag_q & $past(fall)) == $past(fall)));

    // R4: a flag read with no concurrent edge leaves all flags clear
    p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && addr_i == ADDR_FLAG && fall == '0) |=> (flag_q == '0));

    // R5: a same-edge event survives the read-clear
    p_same_edge_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && addr_i == ADDR_FLAG && fall != '0) |=> (flag_q != '0));

    // R6: a mask write lands in the mask
    p_mask_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == ADDR_MASK) |=> (mask == $past(wdata_i[N_SRC-1:0])));

    // R7: clearing the whole mask drops the request
    p_mask_off_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == ADDR_MASK && wdata_i[N_SRC-1:0] == '0) |=> !irq_o);

    // R8: a flag write with no read or edge changes nothing
    p_flag_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !rd_i && addr_i == ADDR_FLAG && fall == '0) |=> $stable(flag_q));

    // R9: the spare data bit always reads zero
    p_spare_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_o[REG_W-1] == 1'b0);
endmodule

bind tmr_irq_unit tmr_irq_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o),
    .flag_q(flag_w), .fall(fall_w), .mask(mask_w)
);

// File: tb/sim_tmr_irq_unit.sv
// Self-checking bench: vector table walk, then directed corner tests.
module sim_tmr_irq_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       addr_i = 1'b0;
    logic       rd_i = 1'b0;
    logic       wr_i = 1'b0;
    logic [3:0] wdata_i = '0;
    logic [3:0] rdata_o;
    logic       irq_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    tmr_irq_unit u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .addr_i(addr_i),
        .rd_i(rd_i), .wr_i(wr_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .irq_o(irq_o)
    );

    // Vector fields: req[19:16] op[15:12] arg[11:4] exp[3:0]
    localparam logic [3:0] OP_TICK = 4'd0, OP_WMASK = 4'd1, OP_RFLAG = 4'd2,
                           OP_RMASK = 4'd3, OP_IRQ = 4'd4, OP_WFLAG = 4'd5;
    localparam int NV = 26;
    localparam logic [19:0] VEC [NV] = '{
        {4'd9, OP_RFLAG, 8'd0,   4'h0},  // R9 flags clear after reset
        {4'd9, OP_RMASK, 8'd0,   4'h0},  // R9 mask clear after reset
        {4'd9, OP_IRQ,   8'd0,   4'h0},  // R9 no request after reset
        {4'd1, OP_TICK,  8'd7,   4'h0},
        {4'd1, OP_RFLAG, 8'd0,   4'h0},  // R1 nothing before 8th tick
        {4'd1, OP_TICK,  8'd1,   4'h0},
        {4'd3, OP_IRQ,   8'd0,   4'h0},  // R3 masked flag gives no request
        {4'd3, OP_RFLAG, 8'd0,   4'h1},  // R3 R1 32 Hz flag recorded while masked
        {4'd4, OP_RFLAG, 8'd0,   4'h0},  // R4 cleared by previous read
        {4'd6, OP_WMASK, 8'h0F,  4'h0},
        {4'd6, OP_RMASK, 8'd0,   4'h7},  // R6 mask readback, bit 3 zero
        {4'd1, OP_TICK,  8'd24,  4'h0},
        {4'd7, OP_IRQ,   8'd0,   4'h1},  // R7 enabled flag raises request
        {4'd1, OP_RFLAG, 8'd0,   4'h3},  // R1 8 Hz flag at 32 ticks
        {4'd7, OP_IRQ,   8'd0,   4'h0},  // R7 request drops after clear
        {4'd6, OP_WMASK, 8'h04,  4'h0},
        {4'd1, OP_TICK,  8'd96,  4'h0},
        {4'd8, OP_WFLAG, 8'h00,  4'h0},
        {4'd7, OP_IRQ,   8'd0,   4'h1},  // R7 2 Hz enabled
        {4'd8, OP_RFLAG, 8'd0,   4'h7},  // R8 R1 write ignored, 2 Hz flag at 128
        {4'd6, OP_WMASK, 8'h01,  4'h0},
        {4'd1, OP_TICK,  8'd4,   4'h0},
        {4'd1, OP_IRQ,   8'd0,   4'h0},  // R1 no 32 Hz event mid-period
        {4'd1, OP_TICK,  8'd4,   4'h0},
        {4'd7, OP_IRQ,   8'd0,   4'h1},  // R7 R1 32 Hz event at 136
        {4'd4, OP_RFLAG, 8'd0,   4'h1}   // R4 read returns flag
    };

    task automatic check(input int req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick_i = 1'b1;
            @(negedge clk) tick_i = 1'b0;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic rd(input logic a, output logic [3:0] v);
        @(negedge clk);
        addr_i = a; rd_i = 1'b1;
        #1 v = rdata_o;
        @(negedge clk) rd_i = 1'b0;
    endtask

    task automatic wr(input logic a, input logic [3:0] d);
        @(negedge clk);
        addr_i = a; wdata_i = d; wr_i = 1'b1;
        @(negedge clk) wr_i = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        logic [3:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < NV; k++) begin
            case (VEC[k][15:12])
                OP_TICK:  ticks(int'(VEC[k][11:4]));
                OP_WMASK: wr(1'b1, VEC[k][7:4]);
                OP_WFLAG: wr(1'b0, VEC[k][7:4]);
                OP_RFLAG: begin rd(1'b0, v); check(int'(VEC[k][19:16]), v, VEC[k][3:0]); end
                OP_RMASK: begin rd(1'b1, v); check(int'(VEC[k][19:16]), v, VEC[k][3:0]); end
                OP_IRQ:   begin @(negedge clk); #1 check(int'(VEC[k][19:16]), {3'b0, irq_o}, VEC[k][3:0]); end
                default:  ;
            endcase
        end
        // R5: event and read-clear on the same edge (divider at 136 -> 144)
        ticks(7);
        @(negedge clk) tick_i = 1'b1;
        @(negedge clk) begin tick_i = 1'b0; addr_i = 1'b0; rd_i = 1'b1; end
        #1 check(5, rdata_o, 4'h0);          // R5 old value returned
        @(negedge clk) rd_i = 1'b0;
        rd(1'b0, v);
        check(5, v, 4'h1);                   // R5 flag survived
        // R2: latency from a tick to the request (divider 144 -> 152)
        ticks(7);
        @(negedge clk) tick_i = 1'b1;
        @(negedge clk) tick_i = 1'b0;
        #1 check(2, {3'b0, irq_o}, 4'h0);    // R2 not yet visible
        @(negedge clk);
        #1 check(2, {3'b0, irq_o}, 4'h1);    // R2 visible after second edge
        // R9: reset mid-run clears flags and mask
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        addr_i = 1'b0;
        #1 check(9, rdata_o, 4'h0);          // R9 flags
        check(9, {3'b0, irq_o}, 4'h0);       // R9 request
        addr_i = 1'b1;
        #1 check(9, rdata_o, 4'h0);          // R9 mask
        @(negedge clk) rst_n = 1'b1;
        // R9: divider cleared, so the first 32 Hz event is again at 8 ticks
        ticks(7);
        rd(1'b0, v);
        check(9, v, 4'h0);
        ticks(1);
        rd(1'b0, v);
        check(9, v, 4'h1);
        done = 1;
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            finish_run();
        end
    end
endmodule